// File: doc/BRIEF.md
# Stimulation-Synchronized Recording Blanking Sequencer

This block sequences one biphasic stimulation event and, from the same clock-cycle timebase, the window during which a recording channel's input switch must stay open. An accepted trigger runs a fixed order of states. A one-cycle lead-in comes first. A programmable leading guard follows, then the cathodic phase, the inter-phase gap, the anodic phase and a programmable trailing guard, and a one-cycle tail closes the event. The blanking output is high across all of these states, so it covers the stimulation on both sides.

A second mode fits the event into the ADC sampling grid. The trigger is held back until the next ADC sample request, and the event starts right after that sample is taken. A request that arrives while the event is still running is not passed on to the ADC. A hold-repeat pulse is given in its place, so the previous value is used again. All durations and the mode are captured when a trigger is accepted. A trigger that arrives while a sequence is busy is dropped and counted. A trigger with a zero-length stimulation phase is refused and flagged.

Top module: `blank_seq_top`

## Requirements
- R1: After reset, all phase enables, `rec_blank`, `adc_strobe`, `hold_valid`, `hold_repeat` and `cfg_err` are 0, and `ovr_count` is 0.
- R2: In direct mode (`align_mode`=0), an accepted trigger at clock edge e raises `rec_blank` right after e. `stim_cath` rises exactly 1+L cycles after `rec_blank` rises and stays high for C cycles, where L is the leading guard and C the cathodic width.
- R3: The phases come in the order cathodic, then gap (G cycles), then anodic (A cycles). At most one phase enable is high in any cycle.
- R4: `rec_blank` stays high for exactly L+C+G+A+T+2 cycles and falls T+1 cycles after `stim_anod` falls, where T is the trailing guard.
- R5: A zero leading guard, gap or trailing guard removes that state. With L=0, `stim_cath` rises one cycle after `rec_blank`. With G=0, `stim_anod` follows `stim_cath` with no gap.
- R6: A trigger in idle with a zero cathodic or anodic width starts no sequence. `cfg_err` goes to 1 from the next cycle and returns to 0 only at the next accepted trigger.
- R7: A trigger that arrives while a sequence is pending or running has no effect on the outputs. It increments `ovr_count`, which saturates at 2^OVR_W-1.
- R8: Durations and mode are captured at acceptance. Changes to them during a sequence do not alter its timing.
- R9: In aligned mode (`align_mode`=1), an accepted trigger waits. The sequence starts, with `rec_blank` high, in the same cycle that `adc_strobe` is output for the first `adc_req` after acceptance.
- R10: `adc_strobe` is `adc_req` delayed by one cycle. The exception is in aligned mode: when the request arrives while the previous cycle's state was part of the blanking window, `adc_strobe` stays 0 and `hold_repeat` pulses instead. `hold_valid` is high in every blanking cycle of an aligned sequence. In direct mode, strobes pass even while blanking.
- R11: After a sequence ends, the next trigger is accepted, so events can be repeated indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Stimulation request |
| align_mode | input | 1 | 1 = align the event to the ADC sample grid |
| lead_cyc | input | 16 | Leading guard length in cycles |
| cath_cyc | input | 16 | Cathodic phase length in cycles |
| ipg_cyc | input | 16 | Inter-phase gap length in cycles |
| anod_cyc | input | 16 | Anodic phase length in cycles |
| trail_cyc | input | 16 | Trailing guard length in cycles |
| adc_req | input | 1 | ADC sample request pulse |
| stim_cath | output | 1 | Cathodic phase enable |
| stim_gap | output | 1 | Inter-phase gap indicator |
| stim_anod | output | 1 | Anodic phase enable |
| rec_blank | output | 1 | Recording input switch disable |
| adc_strobe | output | 1 | Sample strobe to the ADC |
| hold_valid | output | 1 | Held sample in use (aligned mode) |
| hold_repeat | output | 1 | Pulse replacing a suppressed strobe |
| cfg_err | output | 1 | Last trigger was refused for a zero phase width |
| ovr_count | output | OVR_W | Saturating count of dropped triggers |

## Verification
Direct-mode events are run with all guards non-zero and then with every optional state set to zero. Comparing the two separates correct skipping from counter off-by-one faults. A long event carries a burst of extra triggers and altered duration inputs, which shows that busy-time stimulus changes nothing but the counter. The burst is sized so the counter reaches saturation. Aligned-mode events are run with a second sample request that falls just after the window in one case and inside it in the other. This tells a correct strobe gate apart from one that always or never suppresses, and checks that the deferred start lines up with the strobe. Zero-width triggers confirm the refusal and the error flag, and a valid trigger afterwards confirms the flag clears.

// File: rtl/blank_pkg.sv
package blank_pkg;

    parameter int DUR_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRE,
        ST_LEAD,
        ST_CATH,
        ST_IPG,
        ST_ANOD,
        ST_TRAIL,
        ST_POST
    } seq_state_t;

    typedef struct packed {
        logic [DUR_W-1:0] lead;
        logic [DUR_W-1:0] cath;
        logic [DUR_W-1:0] ipg;
        logic [DUR_W-1:0] anod;
        logic [DUR_W-1:0] trail;
    } dur_set_t;

    // successor of a timed state, skipping zero-length optional states
    function automatic seq_state_t step_from(seq_state_t s, dur_set_t d);
        case (s)
            ST_PRE:   return (d.lead  != '0) ? ST_LEAD  : ST_CATH;
            ST_LEAD:  return ST_CATH;
            ST_CATH:  return (d.ipg   != '0) ? ST_IPG   : ST_ANOD;
            ST_IPG:   return ST_ANOD;
            ST_ANOD:  return (d.trail != '0) ? ST_TRAIL : ST_POST;
            ST_TRAIL: return ST_POST;
            default:  return ST_IDLE;
        endcase
    endfunction

    // number of cycles spent in a state
    function automatic logic [DUR_W-1:0] span_of(seq_state_t s, dur_set_t d);
        case (s)
            ST_LEAD:  return d.lead;
            ST_CATH:  return d.cath;
            ST_IPG:   return d.ipg;
            ST_ANOD:  return d.anod;
            ST_TRAIL: return d.trail;
            default:  return DUR_W'(1);
        endcase
    endfunction

    function automatic logic in_window(seq_state_t s);
        return (s == ST_PRE)  || (s == ST_LEAD) || (s == ST_CATH) ||
               (s == ST_IPG)  || (s == ST_ANOD) || (s == ST_TRAIL) ||
               (s == ST_POST);
    endfunction

endpackage

// File: rtl/bs_fsm.sv
module bs_fsm
    import blank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       align_in,
    input  dur_set_t   dur_in,
    input  logic       adc_req,
    output seq_state_t st,
    output logic       align_q,
    output logic       cfg_err,
    output logic       drop_evt
);

    dur_set_t         dq;
    logic [DUR_W-1:0] cnt;
    seq_state_t       nx;
    logic             bad_cfg;

    always_comb begin
        nx       = step_from(st, dq);
        bad_cfg  = (dur_in.cath == '0) || (dur_in.anod == '0);
        drop_evt = trig && (st != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            dq      <= '0;
            align_q <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (trig) begin
                        if (bad_cfg) begin
                            cfg_err <= 1'b1;
                        end else begin
                            cfg_err <= 1'b0;
                            dq      <= dur_in;
                            align_q <= align_in;
                            cnt     <= '0;
                            st      <= align_in ? ST_WAIT : ST_PRE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (adc_req) begin
                        st  <= ST_PRE;
                        cnt <= '0;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st  <= nx;
                        cnt <= span_of(nx, dq) - DUR_W'(1);
                    end else begin
                        cnt <= cnt - DUR_W'(1);
                    end
                end
            endcase
        end
    end

    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && trig && bad_cfg) |=> (st == ST_IDLE && cfg_err)); // R6

    AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(align_q)); // R8

    AST_WAIT_TO_PRE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && adc_req) |=> (st == ST_PRE)); // R9

endmodule

// File: rtl/bs_outmap.sv
module bs_outmap
    import blank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_t st,
    input  logic       align_q,
    input  logic       adc_req,
    output logic       ph_cath,
    output logic       ph_gap,
    output logic       ph_anod,
    output logic       blank,
    output logic       hold_valid,
    output logic       adc_strobe,
    output logic       hold_repeat
);

    logic suppress;

    always_comb begin
        ph_cath    = (st == ST_CATH);
        ph_gap     = (st == ST_IPG);
        ph_anod    = (st == ST_ANOD);
        blank      = in_window(st);
        hold_valid = align_q && in_window(st);
        suppress   = align_q && in_window(st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            adc_strobe  <= 1'b0;
            hold_repeat <= 1'b0;
        end else begin
            adc_strobe  <= adc_req && !suppress;
            hold_repeat <= adc_req && suppress;
        end
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ph_cath, ph_gap, ph_anod})); // R3

    AST_PHASE_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        (ph_cath || ph_gap || ph_anod) |-> blank); // R4

    AST_BLANK_LEADS: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_cath) |-> $past(blank)); // R2

    AST_BLANK_TRAILS: assert property (@(posedge clk) disable iff (rst)
        $fell(blank) |-> !$past(ph_anod)); // R4

    AST_ANOD_ORDER: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_anod) |-> ($past(ph_gap) || $past(ph_cath))); // R3

    AST_STROBE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (adc_strobe && align_q) |-> !(ph_cath || ph_gap || ph_anod)); // R10

    AST_STROBE_XOR: assert property (@(posedge clk) disable iff (rst)
        !(adc_strobe && hold_repeat)); // R10

endmodule

// File: rtl/bs_ovr.sv
module bs_ovr #(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    output logic [OVR_W-1:0] count
);

    localparam logic [OVR_W-1:0] TOP = {OVR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (evt && count != TOP) begin
            count <= count + OVR_W'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count == TOP) |=> (count == TOP)); // R7

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!evt) |=> $stable(count)); // R7

endmodule

// File: rtl/blank_seq_top.sv
module blank_seq_top
    import blank_pkg::*;
#(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             align_mode,
    input  logic [DUR_W-1:0] lead_cyc,
    input  logic [DUR_W-1:0] cath_cyc,
    input  logic [DUR_W-1:0] ipg_cyc,
    input  logic [DUR_W-1:0] anod_cyc,
    input  logic [DUR_W-1:0] trail_cyc,
    input  logic             adc_req,
    output logic             stim_cath,
    output logic             stim_gap,
    output logic             stim_anod,
    output logic             rec_blank,
    output logic             adc_strobe,
    output logic             hold_valid,
    output logic             hold_repeat,
    output logic             cfg_err,
    output logic [OVR_W-1:0] ovr_count
);

    dur_set_t   dur_in;
    seq_state_t st;
    logic       align_q;
    logic       drop_evt;

    always_comb begin
        dur_in.lead  = lead_cyc;
        dur_in.cath  = cath_cyc;
        dur_in.ipg   = ipg_cyc;
        dur_in.anod  = anod_cyc;
        dur_in.trail = trail_cyc;
    end

    bs_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .align_in (align_mode),
        .dur_in   (dur_in),
        .adc_req  (adc_req),
        .st       (st),
        .align_q  (align_q),
        .cfg_err  (cfg_err),
        .drop_evt (drop_evt)
    );

    bs_outmap u_map (
        .clk         (clk),
        .rst         (rst),
        .st          (st),
        .align_q     (align_q),
        .adc_req     (adc_req),
        .ph_cath     (stim_cath),
        .ph_gap      (stim_gap),
        .ph_anod     (stim_anod),
        .blank       (rec_blank),
        .hold_valid  (hold_valid),
        .adc_strobe  (adc_strobe),
        .hold_repeat (hold_repeat)
    );

    bs_ovr #(.OVR_W(OVR_W)) u_ovr (
        .clk   (clk),
        .rst   (rst),
        .evt   (drop_evt),
        .count (ovr_count)
    );

endmodule

// File: tb/sim_blank_seq_top.sv
`timescale 1ns/1ps
module sim_blank_seq_top;

    localparam int OW   = 4;
    localparam int OMAX = 15;

    typedef struct {
        logic [6:0] v;
        logic [6:0] m;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic align_mode = 1'b0;
    logic [15:0] lead_cyc = '0, cath_cyc = '0, ipg_cyc = '0, anod_cyc = '0, trail_cyc = '0;
    logic adc_req = 1'b0;
    logic stim_cath, stim_gap, stim_anod, rec_blank, adc_strobe, hold_valid, hold_repeat, cfg_err;
    logic [OW-1:0] ovr_count;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ovr_m  = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    blank_seq_top #(.OVR_W(OW)) u0 (
        .clk(clk), .rst(rst), .trig(trig), .align_mode(align_mode),
        .lead_cyc(lead_cyc), .cath_cyc(cath_cyc), .ipg_cyc(ipg_cyc),
        .anod_cyc(anod_cyc), .trail_cyc(trail_cyc), .adc_req(adc_req),
        .stim_cath(stim_cath), .stim_gap(stim_gap), .stim_anod(stim_anod),
        .rec_blank(rec_blank), .adc_strobe(adc_strobe), .hold_valid(hold_valid),
        .hold_repeat(hold_repeat), .cfg_err(cfg_err), .ovr_count(ovr_count)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle, sampled 1 ns after the edge
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog R11 actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
        #1;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            check(it.tag,
                  int'({stim_cath, stim_gap, stim_anod, rec_blank, hold_valid, adc_strobe, hold_repeat} & it.m),
                  int'(it.v & it.m));
        end
    end

    // driver: builds the expected cycle-by-cycle picture, then plays stimulus
    task automatic run_seq(string tag, int l, int c, int g, int a, int t,
                           bit al, int d, int p, int ne);
        bit rej = (c == 0) || (a == 0);
        int s   = al ? d : 0;
        int len = l + c + g + a + t + 2;
        int n   = ((s + len) > (d + p) ? (s + len) : (d + p)) + 3;
        bit bl[];
        bl = new[n];
        for (int k = 0; k < n; k++) bl[k] = !rej && (k >= s) && (k < s + len);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            exp_t it;
            int   o   = k - s;
            bit   req = (k == d) || (k == d + p);
            bit   sup = req && al && !rej && (k >= 1) && bl[k-1];
            bit   ca  = bl[k] && (o >= 1 + l) && (o < 1 + l + c);
            bit   ga  = bl[k] && (o >= 1 + l + c) && (o < 1 + l + c + g);
            bit   an  = bl[k] && (o >= 1 + l + c + g) && (o < 1 + l + c + g + a);
            it.v   = {ca, ga, an, bl[k], al && bl[k], req && !sup, sup};
            it.m   = 7'h7f;
            it.tag = tag;
            q.push_back(it);
        end
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 0) begin
                lead_cyc = 16'(l); cath_cyc = 16'(c); ipg_cyc = 16'(g);
                anod_cyc = 16'(a); trail_cyc = 16'(t); align_mode = al;
            end
            if (k == 1) begin
                // R8: busy-time input changes must not matter
                lead_cyc = 16'd7; cath_cyc = 16'd0; ipg_cyc = 16'd9;
                anod_cyc = 16'd0; trail_cyc = 16'd5; align_mode = ~al;
            end
            trig    = (k == 0) || (k >= 2 && k < 2 + ne);
            adc_req = (k == d) || (k == d + p);
        end
        @(negedge clk);
        trig = 1'b0;
        adc_req = 1'b0;
        while (q.size() > 0) @(negedge clk);
        ovr_m = (ovr_m + ne > OMAX) ? OMAX : ovr_m + ne;
        check({tag, " R7 ovr"}, int'(ovr_count), ovr_m);
        check({tag, " R6 err"}, int'(cfg_err), int'(rej));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 phases", int'({stim_cath, stim_gap, stim_anod, rec_blank}), 0);
        check("R1 strobe", int'({adc_strobe, hold_valid, hold_repeat}), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
        check("R1 ovr", int'(ovr_count), 0);

        run_seq("R2 R3 R4 direct", 3, 4, 2, 4, 3, 1'b0, 0, 5, 0);
        run_seq("R5 zero guards", 0, 1, 0, 1, 0, 1'b0, 0, 2, 0);
        run_seq("R6 zero cath", 2, 0, 1, 3, 1, 1'b0, 0, 2, 0);
        run_seq("R6 clear", 1, 2, 1, 2, 1, 1'b0, 0, 3, 0);
        run_seq("R6 zero anod", 1, 2, 1, 0, 1, 1'b0, 0, 2, 0);
        run_seq("R7 R8 overrun", 40, 2, 1, 2, 1, 1'b0, 0, 7, 3);
        run_seq("R7 saturate", 40, 2, 1, 2, 1, 1'b0, 0, 9, 20);
        run_seq("R9 R10 aligned fits", 1, 2, 1, 2, 1, 1'b1, 3, 12, 0);
        run_seq("R10 aligned suppress", 2, 5, 1, 5, 2, 1'b1, 1, 6, 2);
        run_seq("R11 repeat a", 2, 3, 1, 3, 2, 1'b0, 0, 4, 0);
        run_seq("R11 repeat b", 2, 3, 1, 3, 2, 1'b0, 0, 4, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule